// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Model

This block behaves like the device side of a multichannel delta-sigma converter's four-wire serial port, so a host-side controller can be exercised without the real chip. Internally it steps through three phases: converting, sleeping with a result ready, and a data input/output transfer. The conversion is a fixed delay, counted in system clocks, at whose end the supplied result bus is loaded into an output shift register.

The host lowers chip select and clocks the port. Each transfer shifts a 24-bit word out on the data output and collects an 8-bit channel-select word from the data input. When the word is complete, or when chip select rises early, a new conversion begins. A channel-select word is applied only if at least eight falling clock edges were seen and its leading bits and enable bit are valid. Chip select, serial clock and serial data are brought into the system clock domain through synchronizer chains. All results are therefore seen a few system clocks after each serial edge, and the serial clock must be slow compared with the system clock.

Top module: `adc_port_emu`

## Requirements
- R1: During reset and right after it, `chan_cfg` equals `CHAN_RST` (default 0) and a conversion starts at once.
- R2: `sdo_oe` is high exactly while the synchronized chip select is low. While it is low, `sdo` reads 0.
- R3: A conversion lasts `CONV_CYCLES` system clocks. While chip select is low and a conversion runs, `sdo` is 1. Once the result is ready, `sdo` shows 0, which acts as an end-of-conversion flag.
- R4: With a result ready, the port stays asleep until a serial clock rising edge arrives while chip select is low. Toggling chip select alone changes nothing.
- R5: The output word is, first bit to last: ready flag (0), a constant 0, then the 22 bits of `conv_data` from bit 21 down. Bit k of this sequence (k from 0) is valid before rising edge k+1. The port changes it only on falling edges.
- R6: `conv_data` is captured in the clock cycle in which the conversion ends, and it is held while the port sleeps.
- R7: On the 24th falling edge a new conversion begins and `sdo` goes to 1.
- R8: Data input is sampled on the first eight rising edges, first bit as bit 7. Bits [7:6] are a prefix, bit 5 is enable, bit 4 selects single-ended, bit 3 is the odd/polarity bit, and bits [2:0] are the address. `chan_cfg` = {bit4, bit3, bits[2:0]}.
- R9: A select word is applied only when its prefix is 2'b10 and its enable bit is 1. Otherwise the previous `chan_cfg` stays.
- R10: A chip select rising edge during a transfer ends it and starts a new conversion at once.
- R11: An ended transfer applies its select word only if at least eight falling edges were seen before chip select rose.
- R12: `chan_cfg` changes only in the cycle in which the conversion following a transfer starts. It never changes inside a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock from host, asynchronous |
| sdi | input | 1 | Serial data from host |
| conv_data | input | RES_BITS+1 | Sign and result bits loaded at conversion end |
| sdo | output | 1 | Serial data to host, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for `sdo` |
| chan_cfg | output | 5 | Active channel: single-ended, odd, address[2:0] |

## Verification
Every cycle, the checker confirms these points. The conversion length is exact. Leaving sleep needs a qualified rising clock edge. The shifted bit is frozen while asleep. The falling-edge count never passes the word length. A transfer ends only on chip select or on the last falling edge. The channel register moves only when a conversion starts after a transfer. Only the bench scenarios can show the rest: the content and order of the output word, the decoding of the select word, the eight-edge commit threshold for early termination, and the end-of-conversion flag seen at the pins.

// File: rtl/adc_port_pkg.sv
// Shared definitions for the serial port model: phase encoding and the
// layout constants of the channel-select word. Assumes nothing else.
package adc_port_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_XFER  = 2'd2
    } port_state_t;

    localparam int          SEL_W      = 8;
    localparam int          CFG_W      = 5;
    localparam logic [1:0]  SEL_PREFIX = 2'b10;
    localparam int          SEL_EN_BIT = 5;

endpackage

// File: rtl/adc_port_sync.sv
// Multi-bit synchronizer. Each bit passes through its own chain of STAGES
// flops. Assumes the bits are independent and slow against clk.
module adc_port_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] pipe;

        // Shift the raw input through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
            else        pipe <= {pipe[STAGES-2:0], async_in[g]};
        end

        assign sync_out[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/adc_port_conv_timer.sv
// Conversion delay counter. It runs from reset or from start, and raises done
// in its final cycle. Assumes CONV_CYCLES >= 1.
module adc_port_conv_timer #(
    parameter int CONV_CYCLES = 1000,
    localparam int CCW = $clog2(CONV_CYCLES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           done,
    output logic [CCW-1:0] count
);

    localparam logic [CCW-1:0] LAST = CCW'(CONV_CYCLES - 1);

    logic running;

    // Count conversion cycles and stop at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b1;
            count   <= '0;
        end else if (start) begin
            running <= 1'b1;
            count   <= '0;
        end else if (running) begin
            if (count == LAST) running <= 1'b0;
            else               count   <= count + 1'b1;
        end
    end

    assign done = running && (count == LAST);

endmodule

// File: rtl/adc_port_shifter.sv
// Serial datapath. The output shift register shifts on qualified falling
// edges. The input word is collected on the first SEL_W qualified rising
// edges, and the falling edges are counted. Load clears all of it.
module adc_port_shifter
    import adc_port_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int FCW = $clog2(WORD_W + 1),
    localparam int RCW = $clog2(SEL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_in,
    input  logic              shift_out,
    input  logic              sdi_bit,
    output logic              out_msb,
    output logic [SEL_W-1:0]  sel_word,
    output logic [FCW-1:0]    fall_cnt,
    output logic              sel_full
);

    logic [WORD_W-1:0] out_sr;
    logic [RCW-1:0]    rise_cnt;

    // Hold the result word and shift it MSB first, filling the back with ones.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_sr <= '1;
        else if (load)      out_sr <= load_word;
        else if (shift_out) out_sr <= {out_sr[WORD_W-2:0], 1'b1};
    end

    // Collect the first SEL_W input bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sel_word <= '0;
            rise_cnt <= '0;
        end else if (shift_in && rise_cnt != RCW'(SEL_W)) begin
            sel_word <= {sel_word[SEL_W-2:0], sdi_bit};
            rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // Count falling edges, saturating at the word length.
    always_ff @(posedge clk) begin
        if (!rst_n || load)                          fall_cnt <= '0;
        else if (shift_out && fall_cnt != FCW'(WORD_W)) fall_cnt <= fall_cnt + 1'b1;
    end

    assign out_msb  = out_sr[WORD_W-1];
    assign sel_full = (fall_cnt >= FCW'(SEL_W));

endmodule

// File: rtl/adc_port_emu.sv
// Device-side model of a delta-sigma converter's four-wire serial port.
// Phases: conversion (fixed delay) -> sleep with a result -> transfer.
// Assumes sck and cs_n change slowly against clk; all serial pins are
// synchronized here, so responses lag each pin edge by a few clocks.
module adc_port_emu
    import adc_port_pkg::*;
#(
    parameter int               RES_BITS    = 21,
    parameter int               CONV_CYCLES = 1000,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0] CHAN_RST    = '0,
    localparam int DATA_W = RES_BITS + 1,
    localparam int WORD_W = RES_BITS + 3,
    localparam int FCW    = $clog2(WORD_W + 1),
    localparam int CCW    = $clog2(CONV_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [CFG_W-1:0]  chan_cfg
);

    logic [2:0]       pins_s;
    logic             cs_lvl, sck_lvl, sdi_lvl;
    logic [1:0]       edge_q;
    logic             cs_rise, sck_rise, sck_fall;
    port_state_t      state, state_nxt;
    logic             conv_start, conv_done, load, commit;
    logic [CCW-1:0]   conv_cnt;
    logic             shift_in, shift_out, out_msb, sel_full;
    logic [SEL_W-1:0] sel_word;
    logic [FCW-1:0]   fall_cnt;
    logic             sel_ok;

    adc_port_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sck, sdi}),
        .sync_out (pins_s)
    );

    assign cs_lvl  = pins_s[2];
    assign sck_lvl = pins_s[1];
    assign sdi_lvl = pins_s[0];

    // Remember the previous chip select and clock levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= 2'b10;
        else        edge_q <= {cs_lvl, sck_lvl};
    end

    assign cs_rise  =  cs_lvl  & ~edge_q[1];
    assign sck_rise =  sck_lvl & ~edge_q[0];
    assign sck_fall = ~sck_lvl &  edge_q[0];

    adc_port_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .done  (conv_done),
        .count (conv_cnt)
    );

    assign shift_in  = sck_rise && !cs_lvl && (state != ST_CONV);
    assign shift_out = sck_fall && !cs_lvl && (state == ST_XFER);

    adc_port_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word ({1'b0, 1'b0, conv_data}),
        .shift_in  (shift_in),
        .shift_out (shift_out),
        .sdi_bit   (sdi_lvl),
        .out_msb   (out_msb),
        .sel_word  (sel_word),
        .fall_cnt  (fall_cnt),
        .sel_full  (sel_full)
    );

    // Choose the next phase and the one-cycle actions that go with it.
    always_comb begin
        state_nxt  = state;
        conv_start = 1'b0;
        load       = 1'b0;
        commit     = 1'b0;
        case (state)
            ST_CONV: begin
                if (conv_done) begin
                    state_nxt = ST_SLEEP;
                    load      = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (sck_rise && !cs_lvl) state_nxt = ST_XFER;
            end
            ST_XFER: begin
                if (cs_rise) begin
                    state_nxt  = ST_CONV;
                    conv_start = 1'b1;
                    commit     = sel_full;
                end else if (shift_out && fall_cnt == FCW'(WORD_W - 1)) begin
                    state_nxt  = ST_CONV;
                    conv_start = 1'b1;
                    commit     = 1'b1;
                end
            end
            default: state_nxt = ST_CONV;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CONV;
        else        state <= state_nxt;
    end

    assign sel_ok = (sel_word[SEL_W-1 -: 2] == SEL_PREFIX) && sel_word[SEL_EN_BIT];

    // Apply a valid select word as the next conversion begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                chan_cfg <= CHAN_RST;
        else if (commit && sel_ok) chan_cfg <= sel_word[CFG_W-1:0];
    end

    assign sdo_oe = ~cs_lvl;
    assign sdo    = sdo_oe & ((state == ST_CONV) ? 1'b1 : out_msb);

endmodule

// File: rtl/adc_port_emu_chk.sv
// Protocol checker for adc_port_emu, attached by bind. It observes the phase
// register, the edge strobes, the counters and the channel output.
module adc_port_emu_chk
    import adc_port_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CONV_CYCLES = 1000,
    parameter int FCW         = 5,
    parameter int CCW         = 10
) (
    input logic             clk,
    input logic             rst_n,
    input port_state_t      state,
    input logic             cs_lvl,
    input logic             cs_rise,
    input logic             sck_rise,
    input logic [FCW-1:0]   fall_cnt,
    input logic [CCW-1:0]   conv_cnt,
    input logic             out_msb,
    input logic [CFG_W-1:0] chan_cfg
);

    // R12
    chan_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_cfg) |-> (state == ST_CONV && $past(state) == ST_XFER));

    // R7
    fall_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= FCW'(WORD_W));

    // R4
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && $past(state) == ST_SLEEP) |-> $past(sck_rise && !cs_lvl));

    // R3
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) == ST_CONV) |-> $past(conv_cnt) == CCW'(CONV_CYCLES - 1));

    // R10
    xfer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && $past(state) == ST_XFER) |-> ($past(cs_rise) || $past(fall_cnt) == FCW'(WORD_W - 1)));

    // R6
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> $stable(out_msb));

endmodule

bind adc_port_emu adc_port_emu_chk #(
    .WORD_W      (WORD_W),
    .CONV_CYCLES (CONV_CYCLES),
    .FCW         (FCW),
    .CCW         (CCW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .cs_lvl   (cs_lvl),
    .cs_rise  (cs_rise),
    .sck_rise (sck_rise),
    .fall_cnt (fall_cnt),
    .conv_cnt (conv_cnt),
    .out_msb  (out_msb),
    .chan_cfg (chan_cfg)
);

// File: tb/adc_port_emu_bench.sv
// Host-side bench: full transfers over every channel code and bad select
// words, then transfers ended early after each count of falling edges.
module adc_port_emu_bench;

    localparam int RB   = 21;
    localparam int DW   = RB + 1;
    localparam int CONV = 40;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          sdo, sdo_oe;
    logic [4:0]    chan_cfg;

    int            checks = 0;
    int            errors = 0;
    int            didx   = 0;
    logic [DW-1:0] cur_data;
    logic [4:0]    exp_chan = 5'd0;

    always #4 clk = ~clk;

    adc_port_emu #(
        .RES_BITS    (RB),
        .CONV_CYCLES (CONV)
    ) u_adc_port_emu (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .sdi       (sdi),
        .conv_data (conv_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .chan_cfg  (chan_cfg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        if (i == 1) return '1;
        if (i == 2) return '0;
        return DW'(i * 32'h000B5A3) ^ DW'(32'h2A5C3F);
    endfunction

    function automatic logic [7:0] sel_for(input int t);
        case (t)
            32:      return {2'b00, 1'b1, 5'h15};
            33:      return {2'b01, 1'b1, 5'h0A};
            34:      return {2'b11, 1'b1, 5'h1F};
            35:      return {2'b10, 1'b0, 5'h11};
            default: return {2'b10, 1'b1, 5'(t)};
        endcase
    endfunction

    task automatic sck_cycle(input logic d, output logic s);
        sdi = d;
        repeat (HALF) @(negedge clk);
        s = sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!(sdo_oe && sdo == 1'b0) && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // One transfer of nfall clocks; nfall < 24 ends it early with chip select.
    task automatic run_xfer(input logic [7:0] sel, input int nfall);
        logic [23:0] word;
        logic [4:0]  old;
        logic        b;
        int          n;
        word = {2'b00, cur_data};
        old  = exp_chan;
        for (int i = 0; i < nfall; i++) begin
            sck_cycle((i < 8) ? sel[7-i] : 1'b0, b);
            chk("R5 output bit", b, word[23-i]);
            if (i == 12) chk("R12 channel held inside transfer", chan_cfg, old);
        end
        if (nfall < 24) begin
            repeat (HALF) @(negedge clk);
            cs_n = 1'b1;
            repeat (8) @(negedge clk);
            chk("R2 output disabled", sdo_oe, 1'b0);
        end else begin
            repeat (8) @(negedge clk);
            chk("R7 conversion after last edge", sdo, 1'b1);
        end
        if (nfall >= 8 && sel[7:6] == 2'b10 && sel[5]) exp_chan = sel[4:0];
        chk((nfall < 24) ? "R11 channel after early end" : "R9 channel after transfer",
            chan_cfg, exp_chan);
        didx++;
        cur_data  = pat(didx);
        conv_data = cur_data;
        if (nfall < 24) begin
            cs_n = 1'b0;
            repeat (2) @(negedge clk);
            chk("R10 conversion after early end", sdo, 1'b1);
        end
        wait_ready(n);
        chk("R3 conversion length", (n >= CONV - 14 && n <= CONV), 1'b1);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        cur_data  = pat(0);
        conv_data = cur_data;
        repeat (5) @(negedge clk);
        chk("R1 reset disables output", sdo_oe, 1'b0);
        chk("R1 reset channel", chan_cfg, 5'd0);
        rst_n = 1'b1;
        cs_n  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 output enabled", sdo_oe, 1'b1);
        chk("R3 busy flag during conversion", sdo, 1'b1);
        wait_ready(n);
        chk("R1 conversion from reset", (n >= CONV - 14 && n <= CONV), 1'b1);

        // R4: chip select toggles alone must not disturb the sleeping port
        cs_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 output disabled", sdo_oe, 1'b0);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 still asleep with result", sdo, 1'b0);

        // R8 R9: every channel code, then bad prefixes and enable off
        for (int t = 0; t < 36; t++) run_xfer(sel_for(t), 24);

        // R11: early end after each count of falling edges
        for (int k = 1; k < 24; k++) begin
            logic [7:0] s;
            s = {2'b10, 1'b1, 5'(k * 5 + 3)};
            if (s[4:0] == exp_chan) s[0] = ~s[0];
            run_xfer(s, k);
        end

        finish_run();
    end

endmodule